// File: doc/BRIEF.md
# Byte-Bus Serial Port Register Interface

This block is the processor-side register file of a classic asynchronous serial port. A byte-wide bus with a 3-bit offset reaches eight register slots. Several slots hold two registers. Which one is reached depends on whether the access is a read or a write, and on a divisor-select bit in the line control register.

Characters written by software collect in a transmit queue. The queue is presented to an external shift engine through a valid/ready pair. Characters arriving from the shift engine, each with its parity, framing and break flags, collect in a receive queue. Software drains that queue by reading the data slot.

A line status byte, an interrupt identification byte and an interrupt request output let software work by polling or by interrupt. Bit timing, baud generation and modem pins belong to other blocks. The block only hands the divisor and the modem control bits to them.

Top module: `uart_regif`

## Requirements
- R1: After reset the line status register (offset 5) reads 0x60 with the engine idle, the identification register (offset 2) reads 0xC1, and irq and tx_valid are 0.
- R2: Offsets 3, 4, 7 and 1 read back the last value written. Offset 3 and offset 7 keep all 8 bits, offset 4 keeps bits 4:0, and offset 1 keeps bits 3:0. Reading offset 7 has no side effect.
- R3: While line control bit 7 is 1, offsets 0 and 1 read and write the low and high divisor bytes, and `divisor` shows {high,low}. Data and the interrupt enable register are untouched.
- R4: A write to offset 0 with line control bit 7 at 0 queues one byte in a 16-entry transmit FIFO, which is offered oldest first on tx_data/tx_valid and removed when tx_ready is 1. A write to a full FIFO is dropped.
- R5: Line status bit 5 is 1 when the transmit FIFO is empty. Bit 6 is 1 only when that FIFO is empty and tx_idle is 1.
- R6: A byte arriving with rx_valid enters a 16-entry receive FIFO. Line status bit 0 is 1 while that FIFO holds data. A read of offset 0 with line control bit 7 at 0 returns the oldest byte and removes it.
- R7: A byte arriving while the receive FIFO is full, with no removal in the same cycle, is dropped and sets line status bit 1. That bit clears on the next read of offset 5.
- R8: Line status bits 2, 3 and 4 show the parity, framing and break flags of the oldest received byte. Bit 7 is 1 while any byte in the receive FIFO carries a flag.
- R9: A write to offset 2 with bit 1 set empties the receive FIFO. With bit 2 set, it empties the transmit FIFO.
- R10: Interrupt enable bit 2 enables line errors (bit 1 of the line status register or a flag on the oldest byte). Bit 0 enables received data, and bit 1 enables an empty transmit FIFO. Offset 2 reads 0xC6, 0xC4 or 0xC2 for the highest pending enabled source, in that priority order, and 0xC1 when none is pending. irq is 1 exactly when one is pending.
- R11: When a byte arrives in the same cycle that software reads offset 0 on a full receive FIFO, the oldest byte is returned, the new byte is kept, and no overrun is flagged.
- R12: Writes to offsets 5 and 6 have no effect, and offset 6 reads 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rd_en | input | 1 | Read strobe; side effects take place at the clock edge |
| wr_en | input | 1 | Write strobe |
| addr | input | 3 | Register offset |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data for addr, valid in the strobe cycle |
| tx_data | output | 8 | Oldest queued transmit byte |
| tx_valid | output | 1 | Transmit FIFO not empty |
| tx_ready | input | 1 | Shift engine takes tx_data |
| tx_idle | input | 1 | Shift engine has finished shifting |
| rx_data | input | 8 | Received byte |
| rx_perr | input | 1 | Parity error on rx_data |
| rx_ferr | input | 1 | Framing error on rx_data |
| rx_brk | input | 1 | Break seen on the line |
| rx_valid | input | 1 | Received byte present this cycle |
| irq | output | 1 | Interrupt request |
| divisor | output | 16 | Baud divisor for the rate generator |
| modem_ctrl | output | 5 | Modem control bits |

## Verification
The receive FIFO can see an arrival from the shift engine and a software read of offset 0 in the same clock. When the FIFO is full, this decides whether the byte is kept or is counted as an overrun. The bench fills the receive FIFO to 16 entries, then raises rx_valid and a read strobe in the same cycle. It checks that the returned byte is the oldest one and that the following status read shows no overrun bit. It then checks that draining gives the 15 remaining bytes followed by the new one. A separate run that overflows with no read in that cycle confirms that the overrun path still triggers.

// File: rtl/uart_regif_pkg.sv
package uart_regif_pkg;
  localparam logic [2:0] OFS_DATA = 3'd0;
  localparam logic [2:0] OFS_IER  = 3'd1;
  localparam logic [2:0] OFS_IIR  = 3'd2;
  localparam logic [2:0] OFS_LCR  = 3'd3;
  localparam logic [2:0] OFS_MCR  = 3'd4;
  localparam logic [2:0] OFS_LSR  = 3'd5;
  localparam logic [2:0] OFS_MSR  = 3'd6;
  localparam logic [2:0] OFS_SCR  = 3'd7;

  typedef enum logic [2:0] {
    SRC_NONE = 3'b000,
    SRC_THRE = 3'b001,
    SRC_RXD  = 3'b010,
    SRC_LINE = 3'b011
  } irq_src_e;

  typedef struct packed {
    logic       brk;
    logic       ferr;
    logic       perr;
    logic [7:0] data;
  } rx_entry_t;
endpackage

// File: rtl/uart_regif_fifo.sv
module uart_regif_fifo #(
  parameter int WIDTH = 8,
  parameter int DEPTH = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             flush,
  input  logic             push,
  input  logic [WIDTH-1:0] wdata,
  input  logic             pop,
  output logic [WIDTH-1:0] rdata,
  output logic             empty,
  output logic             full,
  output logic             push_ok,
  output logic             pop_ok
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);

  logic [WIDTH-1:0] mem [DEPTH];
  logic [AW-1:0] wr_q, wr_d, rd_q, rd_d;
  logic [CW-1:0] cnt_q, cnt_d;

  assign empty   = (cnt_q == '0);
  assign full    = (cnt_q == CW'(DEPTH));
  assign pop_ok  = pop && !empty && !flush;
  assign push_ok = push && (!full || pop_ok) && !flush;
  assign rdata   = mem[rd_q];

  always_comb begin
    wr_d  = wr_q;
    rd_d  = rd_q;
    cnt_d = cnt_q;
    if (flush) begin
      wr_d  = '0;
      rd_d  = '0;
      cnt_d = '0;
    end else begin
      if (push_ok) wr_d = (wr_q == AW'(DEPTH - 1)) ? '0 : wr_q + 1'b1;
      if (pop_ok)  rd_d = (rd_q == AW'(DEPTH - 1)) ? '0 : rd_q + 1'b1;
      cnt_d = cnt_q + CW'(push_ok) - CW'(pop_ok);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_q  <= '0;
      rd_q  <= '0;
      cnt_q <= '0;
    end else begin
      wr_q  <= wr_d;
      rd_q  <= rd_d;
      cnt_q <= cnt_d;
    end
  end

  always_ff @(posedge clk) begin
    if (push_ok) mem[wr_q] <= wdata;
  end
endmodule

// File: rtl/uart_regif_irq.sv
module uart_regif_irq
  import uart_regif_pkg::*;
(
  input  logic [2:0] enable,
  input  logic       line_pend,
  input  logic       rxd_pend,
  input  logic       thre_pend,
  output irq_src_e   src,
  output logic       irq
);
  always_comb begin
    if (enable[2] && line_pend)      src = SRC_LINE;
    else if (enable[0] && rxd_pend)  src = SRC_RXD;
    else if (enable[1] && thre_pend) src = SRC_THRE;
    else                             src = SRC_NONE;
  end
  assign irq = (src != SRC_NONE);
endmodule

// File: rtl/uart_regif.sv
module uart_regif
  import uart_regif_pkg::*;
#(
  parameter int FIFO_DEPTH = 16
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        rd_en,
  input  logic        wr_en,
  input  logic [2:0]  addr,
  input  logic [7:0]  wdata,
  output logic [7:0]  rdata,
  output logic [7:0]  tx_data,
  output logic        tx_valid,
  input  logic        tx_ready,
  input  logic        tx_idle,
  input  logic [7:0]  rx_data,
  input  logic        rx_perr,
  input  logic        rx_ferr,
  input  logic        rx_brk,
  input  logic        rx_valid,
  output logic        irq,
  output logic [15:0] divisor,
  output logic [4:0]  modem_ctrl
);
  localparam int CW = $clog2(FIFO_DEPTH + 1);
  localparam int EW = $bits(rx_entry_t);

  // reset: asserted asynchronously, released on the clock
  logic rst_s1, rst_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_s1 <= 1'b0;
      rst_q  <= 1'b0;
    end else begin
      rst_s1 <= 1'b1;
      rst_q  <= rst_s1;
    end
  end

  logic [7:0] lcr_q, lcr_d, scr_q, scr_d, dll_q, dll_d, dlm_q, dlm_d;
  logic [4:0] mcr_q, mcr_d;
  logic [3:0] ier_q, ier_d;
  logic       oe_q, oe_d;
  logic [CW-1:0] errcnt_q, errcnt_d;

  logic dlab;
  logic tx_push, tx_pop, tx_flush, tx_empty, tx_full, tx_push_ok, tx_pop_ok;
  logic rx_push, rx_pop, rx_flush, rx_empty, rx_full, rx_push_ok, rx_pop_ok;
  logic fcr_wr, lsr_rd, oe_set, head_err, in_err;
  rx_entry_t rx_in, rx_head;
  logic [7:0] lsr;
  irq_src_e   src;

  assign dlab     = lcr_q[7];
  assign tx_push  = wr_en && (addr == OFS_DATA) && !dlab;
  assign rx_pop   = rd_en && (addr == OFS_DATA) && !dlab;
  assign fcr_wr   = wr_en && (addr == OFS_IIR);
  assign rx_flush = fcr_wr && wdata[1];
  assign tx_flush = fcr_wr && wdata[2];
  assign lsr_rd   = rd_en && (addr == OFS_LSR);
  assign tx_pop   = tx_valid && tx_ready;
  assign rx_push  = rx_valid;
  assign rx_in    = '{brk: rx_brk, ferr: rx_ferr, perr: rx_perr, data: rx_data};

  uart_regif_fifo #(.WIDTH(8), .DEPTH(FIFO_DEPTH)) u_txq (
    .clk(clk), .rst_n(rst_q), .flush(tx_flush),
    .push(tx_push), .wdata(wdata), .pop(tx_pop), .rdata(tx_data),
    .empty(tx_empty), .full(tx_full), .push_ok(tx_push_ok), .pop_ok(tx_pop_ok)
  );

  uart_regif_fifo #(.WIDTH(EW), .DEPTH(FIFO_DEPTH)) u_rxq (
    .clk(clk), .rst_n(rst_q), .flush(rx_flush),
    .push(rx_push), .wdata(rx_in), .pop(rx_pop), .rdata(rx_head),
    .empty(rx_empty), .full(rx_full), .push_ok(rx_push_ok), .pop_ok(rx_pop_ok)
  );

  assign tx_valid = !tx_empty;
  assign in_err   = rx_perr || rx_ferr || rx_brk;
  assign head_err = !rx_empty && (rx_head.perr || rx_head.ferr || rx_head.brk);
  assign oe_set   = rx_valid && rx_full && !rx_pop_ok && !rx_flush;

  assign lsr = {(errcnt_q != '0), tx_empty && tx_idle, tx_empty,
                !rx_empty && rx_head.brk, !rx_empty && rx_head.ferr,
                !rx_empty && rx_head.perr, oe_q, !rx_empty};

  uart_regif_irq u_irq (
    .enable(ier_q[2:0]), .line_pend(oe_q || head_err),
    .rxd_pend(!rx_empty), .thre_pend(tx_empty), .src(src), .irq(irq)
  );

  // next-state of the software registers
  always_comb begin
    lcr_d = lcr_q;
    scr_d = scr_q;
    dll_d = dll_q;
    dlm_d = dlm_q;
    mcr_d = mcr_q;
    ier_d = ier_q;
    if (wr_en) begin
      case (addr)
        OFS_DATA: if (dlab) dll_d = wdata;
        OFS_IER:  if (dlab) dlm_d = wdata; else ier_d = wdata[3:0];
        OFS_LCR:  lcr_d = wdata;
        OFS_MCR:  mcr_d = wdata[4:0];
        OFS_SCR:  scr_d = wdata;
        default:  ;
      endcase
    end
    oe_d = oe_set || (oe_q && !lsr_rd);
    if (rx_flush) errcnt_d = '0;
    else          errcnt_d = errcnt_q + CW'(rx_push_ok && in_err)
                                      - CW'(rx_pop_ok && head_err);
  end

  always_ff @(posedge clk or negedge rst_q) begin
    if (!rst_q) begin
      lcr_q    <= '0;
      scr_q    <= '0;
      dll_q    <= '0;
      dlm_q    <= '0;
      mcr_q    <= '0;
      ier_q    <= '0;
      oe_q     <= 1'b0;
      errcnt_q <= '0;
    end else begin
      lcr_q    <= lcr_d;
      scr_q    <= scr_d;
      dll_q    <= dll_d;
      dlm_q    <= dlm_d;
      mcr_q    <= mcr_d;
      ier_q    <= ier_d;
      oe_q     <= oe_d;
      errcnt_q <= errcnt_d;
    end
  end

  always_comb begin
    case (addr)
      OFS_DATA: rdata = dlab ? dll_q : (rx_empty ? 8'h00 : rx_head.data);
      OFS_IER:  rdata = dlab ? dlm_q : {4'b0000, ier_q};
      OFS_IIR:  rdata = {4'b1100, src, !irq};
      OFS_LCR:  rdata = lcr_q;
      OFS_MCR:  rdata = {3'b000, mcr_q};
      OFS_LSR:  rdata = lsr;
      OFS_MSR:  rdata = 8'h00;
      default:  rdata = scr_q;
    endcase
  end

  assign divisor    = {dlm_q, dll_q};
  assign modem_ctrl = mcr_q;
endmodule

// File: rtl/uart_regif_chk.sv
module uart_regif_chk (
  input logic       clk,
  input logic       rst_q,
  input logic       rx_valid,
  input logic       rx_full,
  input logic       rx_empty,
  input logic       rx_pop_ok,
  input logic       rx_flush,
  input logic       tx_full,
  input logic       tx_push,
  input logic       tx_pop_ok,
  input logic       tx_flush,
  input logic [3:0] ier_q,
  input logic [7:0] lsr,
  input logic       irq
);
  assert_overrun_flag_R7: assert property (@(posedge clk) disable iff (!rst_q)
    rx_valid && rx_full && !rx_pop_ok && !rx_flush |=> lsr[1]);

  assert_rx_holds_data_R6: assert property (@(posedge clk) disable iff (!rst_q)
    rx_valid && !rx_flush |=> !rx_empty);

  assert_tx_stays_full_R4: assert property (@(posedge clk) disable iff (!rst_q)
    tx_full && tx_push && !tx_pop_ok && !tx_flush |=> tx_full);

  assert_irq_masked_R10: assert property (@(posedge clk) disable iff (!rst_q)
    (ier_q == 4'h0) |-> !irq);

  assert_temt_implies_thre_R5: assert property (@(posedge clk) disable iff (!rst_q)
    lsr[6] |-> lsr[5]);

  assert_rx_flush_empties_R9: assert property (@(posedge clk) disable iff (!rst_q)
    rx_flush |=> rx_empty);
endmodule

bind uart_regif uart_regif_chk u_chk (
  .clk(clk), .rst_q(rst_q), .rx_valid(rx_valid), .rx_full(rx_full),
  .rx_empty(rx_empty), .rx_pop_ok(rx_pop_ok), .rx_flush(rx_flush),
  .tx_full(tx_full), .tx_push(tx_push), .tx_pop_ok(tx_pop_ok),
  .tx_flush(tx_flush), .ier_q(ier_q), .lsr(lsr), .irq(irq)
);

// File: tb/uart_regif_test.sv
`timescale 1ns/1ps
module uart_regif_test;
  logic clk = 1'b0;
  logic rst_n, rd_en, wr_en, tx_ready, tx_idle;
  logic rx_perr, rx_ferr, rx_brk, rx_valid, tx_valid, irq;
  logic [2:0]  addr;
  logic [7:0]  wdata, rdata, tx_data, rx_data;
  logic [15:0] divisor;
  logic [4:0]  modem_ctrl;
  int checks = 0;
  int failures = 0;

  always #2.5 clk = ~clk;

  uart_regif uut (
    .clk(clk), .rst_n(rst_n), .rd_en(rd_en), .wr_en(wr_en), .addr(addr),
    .wdata(wdata), .rdata(rdata), .tx_data(tx_data), .tx_valid(tx_valid),
    .tx_ready(tx_ready), .tx_idle(tx_idle), .rx_data(rx_data),
    .rx_perr(rx_perr), .rx_ferr(rx_ferr), .rx_brk(rx_brk),
    .rx_valid(rx_valid), .irq(irq), .divisor(divisor), .modem_ctrl(modem_ctrl)
  );

  // {is_write, offset, data or expected read value, requirement number}
  localparam int NV = 16;
  localparam logic [15:0] VEC [NV] = '{
    {1'b1, 3'd3, 8'h1B, 4'd2},  // R2 line control
    {1'b0, 3'd3, 8'h1B, 4'd2},
    {1'b1, 3'd7, 8'hA5, 4'd2},  // R2 scratch
    {1'b0, 3'd7, 8'hA5, 4'd2},
    {1'b0, 3'd7, 8'hA5, 4'd2},  // R2 second read, no side effect
    {1'b1, 3'd4, 8'hFF, 4'd2},  // R2 modem control keeps 4:0
    {1'b0, 3'd4, 8'h1F, 4'd2},
    {1'b1, 3'd1, 8'hF5, 4'd2},  // R2 enable keeps 3:0
    {1'b0, 3'd1, 8'h05, 4'd2},
    {1'b1, 3'd1, 8'h00, 4'd2},
    {1'b0, 3'd1, 8'h00, 4'd2},
    {1'b1, 3'd5, 8'hFF, 4'd12}, // R12 status is read-only
    {1'b0, 3'd5, 8'h60, 4'd12},
    {1'b1, 3'd6, 8'hFF, 4'd12}, // R12 offset 6
    {1'b0, 3'd6, 8'h00, 4'd12},
    {1'b0, 3'd3, 8'h1B, 4'd12}
  };

  task automatic check(input logic [15:0] act, input logic [15:0] exp, input string req);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk);
    addr = a; wdata = d; wr_en = 1'b1;
    @(posedge clk);
    #1 wr_en = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [7:0] d);
    @(negedge clk);
    addr = a; rd_en = 1'b1;
    #1 d = rdata;
    @(posedge clk);
    #1 rd_en = 1'b0;
  endtask

  task automatic rd_chk(input logic [2:0] a, input logic [7:0] exp, input string req);
    logic [7:0] v;
    rd(a, v);
    check({8'h00, v}, {8'h00, exp}, req);
  endtask

  task automatic push(input logic [7:0] d, input logic [2:0] bfp);
    @(negedge clk);
    rx_data = d; {rx_brk, rx_ferr, rx_perr} = bfp; rx_valid = 1'b1;
    @(posedge clk);
    #1 rx_valid = 1'b0; {rx_brk, rx_ferr, rx_perr} = 3'b000;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    logic [7:0] v;
    rst_n = 1'b0; rd_en = 1'b0; wr_en = 1'b0; addr = '0; wdata = '0;
    tx_ready = 1'b0; tx_idle = 1'b1; rx_data = '0;
    rx_perr = 1'b0; rx_ferr = 1'b0; rx_brk = 1'b0; rx_valid = 1'b0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1 reset state
    rd_chk(3'd5, 8'h60, "R1 status");
    rd_chk(3'd2, 8'hC1, "R1 ident");
    check({15'h0, irq}, 16'h0, "R1 irq");
    check({15'h0, tx_valid}, 16'h0, "R1 tx_valid");

    // vector table: R2 and R12
    for (int i = 0; i < NV; i++) begin
      if (VEC[i][15]) wr(VEC[i][14:12], VEC[i][11:4]);
      else begin
        rd(VEC[i][14:12], v);
        check({8'h00, v}, {8'h00, VEC[i][11:4]}, $sformatf("R%0d vector %0d", VEC[i][3:0], i));
      end
    end
    check({11'h0, modem_ctrl}, 16'h001F, "R2 modem_ctrl port");

    // R3 divisor aliasing
    wr(3'd3, 8'h80);
    wr(3'd0, 8'h34);
    wr(3'd1, 8'h12);
    check(divisor, 16'h1234, "R3 divisor port");
    rd_chk(3'd0, 8'h34, "R3 low byte");
    rd_chk(3'd1, 8'h12, "R3 high byte");
    check({15'h0, tx_valid}, 16'h0, "R3 no tx queued");
    wr(3'd3, 8'h03);
    rd_chk(3'd1, 8'h00, "R3 enable untouched");
    rd_chk(3'd5, 8'h60, "R3 status untouched");

    // R4 transmit queue, overflow dropped
    for (int i = 0; i < 16; i++) wr(3'd0, 8'h40 + 8'(i));
    wr(3'd0, 8'h99);
    rd_chk(3'd5, 8'h00, "R4 R5 status with full tx");
    check({7'h0, tx_valid, tx_data}, 16'h0140, "R4 head offered");
    @(negedge clk);
    tx_ready = 1'b1;
    for (int i = 0; i < 16; i++) begin
      check({7'h0, tx_valid, tx_data}, {7'h0, 1'b1, 8'h40 + 8'(i)}, "R4 drain order");
      @(negedge clk);
    end
    check({15'h0, tx_valid}, 16'h0, "R4 overflow byte dropped");
    tx_ready = 1'b0;

    // R5 transmitter empty needs idle engine
    tx_idle = 1'b0;
    rd_chk(3'd5, 8'h20, "R5 busy engine");
    tx_idle = 1'b1;
    rd_chk(3'd5, 8'h60, "R5 idle engine");

    // R6 receive path
    push(8'h11, 3'b000);
    push(8'h22, 3'b000);
    rd_chk(3'd5, 8'h61, "R6 data ready");
    rd_chk(3'd0, 8'h11, "R6 first byte");
    rd_chk(3'd5, 8'h61, "R6 still ready");
    rd_chk(3'd0, 8'h22, "R6 second byte");
    rd_chk(3'd5, 8'h60, "R6 ready clears");

    // R10 and R8 interrupt priority and error flags
    wr(3'd1, 8'h02);
    check({15'h0, irq}, 16'h1, "R10 thre irq");
    rd_chk(3'd2, 8'hC2, "R10 thre ident");
    wr(3'd1, 8'h03);
    push(8'h33, 3'b000);
    rd_chk(3'd2, 8'hC4, "R10 rx ident");
    push(8'h44, 3'b001);
    rd_chk(3'd5, 8'hE1, "R8 error deeper in fifo");
    wr(3'd1, 8'h07);
    rd_chk(3'd2, 8'hC4, "R10 head clean");
    rd_chk(3'd0, 8'h33, "R6 pop clean byte");
    rd_chk(3'd5, 8'hE5, "R8 parity at head");
    rd_chk(3'd2, 8'hC6, "R10 line ident");
    rd_chk(3'd0, 8'h44, "R8 flagged byte data");
    rd_chk(3'd5, 8'h60, "R8 flags gone");
    rd_chk(3'd2, 8'hC2, "R10 back to thre");
    push(8'h55, 3'b110);
    rd_chk(3'd5, 8'hF9, "R8 break and framing");
    rd_chk(3'd0, 8'h55, "R8 pop flagged");
    wr(3'd1, 8'h00);
    check({15'h0, irq}, 16'h0, "R10 all masked");
    rd_chk(3'd2, 8'hC1, "R10 none pending");

    // R7 overrun
    for (int i = 0; i < 16; i++) push(8'h80 + 8'(i), 3'b000);
    push(8'hEE, 3'b000);
    rd_chk(3'd5, 8'h63, "R7 overrun set");
    rd_chk(3'd5, 8'h61, "R7 overrun cleared by read");
    rd_chk(3'd0, 8'h80, "R7 oldest kept");

    // R9 fifo clears
    wr(3'd2, 8'h02);
    rd_chk(3'd5, 8'h60, "R9 rx cleared");
    wr(3'd0, 8'h5A);
    check({15'h0, tx_valid}, 16'h1, "R9 tx queued");
    wr(3'd2, 8'h04);
    check({15'h0, tx_valid}, 16'h0, "R9 tx cleared");
    rd_chk(3'd5, 8'h60, "R9 status after clears");

    // R11 arrival and read in the same cycle on a full fifo
    for (int i = 0; i < 16; i++) push(8'hA0 + 8'(i), 3'b000);
    @(negedge clk);
    addr = 3'd0; rd_en = 1'b1; rx_data = 8'hBB; rx_valid = 1'b1;
    #1 v = rdata;
    @(posedge clk);
    #1 rd_en = 1'b0; rx_valid = 1'b0;
    check({8'h00, v}, 16'h00A0, "R11 oldest returned");
    rd_chk(3'd5, 8'h61, "R11 no overrun");
    for (int i = 1; i < 16; i++) rd_chk(3'd0, 8'hA0 + 8'(i), "R11 remaining order");
    rd_chk(3'd0, 8'hBB, "R11 new byte kept");
    rd_chk(3'd5, 8'h60, "R11 drained");

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule